// File: doc/BRIEF.md
# Modulated Fractional Delay Line

This block is the delay core of a flanger. Each time a sample strobe arrives, it stores the incoming mono sample in an internal sample memory at a write pointer that runs freely. It then works out a read position behind that pointer. The read position is a coarse offset scaled by four, plus the integer byte of a modulation word, plus one more sample. The block fetches the two neighbouring stored samples around that position and blends them with the fraction byte of the modulation word. The blended sample goes to both the left and the right output, and a one-cycle done pulse marks it as valid.

The surrounding control logic supplies the offset and the modulation word; its power-up offset is 9. The memory depth is a parameter. At a 16-bit address the memory holds 64K samples. The default is 2048 entries, which already covers the largest delay the offset and integer byte can request. A strobe is accepted only while the core is idle, and a whole sample takes five clock cycles.

Top module: `fdl_flanger_core`

## Requirements
- R1: After reset, both outputs are 0 and `out_done` is 0.
- R2: Each accepted strobe writes `smp_in` at the write pointer and then advances the pointer by one, modulo 2^ADDR_W. The pointer is 0 after reset, and stored history stays valid across the wrap.
- R3: Tap 0 is read at base = pointer − 4·offset − mod[15:8] − 1 (mod 2^ADDR_W), where pointer is the address the current sample was written to. Tap 1 is read at base + 1.
- R4: The output is floor((tap0·f + tap1·(255 − f)) / 256), where f = mod[7:0] is unsigned and the taps are signed two's-complement.
- R5: The current sample is written before either tap is fetched. With offset 0 and integer byte 0, tap 1 is therefore the sample that arrived with the same strobe.
- R6: `out_left` and `out_right` always carry the same value.
- R7: `out_done` rises exactly four clock edges after the edge that accepts the strobe and stays high for one cycle. The outputs change only on that edge.
- R8: A strobe that arrives while a sample is still being processed is ignored. It writes nothing and does not move the pointer.
- R9: A strobe that arrives in the cycle where `out_done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe, one cycle |
| smp_in | input | 16 | Signed input sample (left channel) |
| offset_in | input | 8 | Coarse delay offset, in units of four samples |
| mod_in | input | 16 | Modulation word: [15:8] integer samples, [7:0] fraction |
| out_left | output | 16 | Delayed signed sample, left |
| out_right | output | 16 | Delayed signed sample, right (same as left) |
| out_done | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
Two events can fall in the same cycle: the delivery of one result with its done pulse, and the acceptance of the next strobe. A long run drives strobes back to back, so that every new strobe is raised in the cycle where done is high. It checks that each of those strobes is accepted and that its output follows the reference history. That run is longer than the memory depth, so it also carries the write pointer through its wrap. A separate case raises a strobe with a different sample in the middle of processing. It then reads the previous location with full weight on tap 0 and judges that the ignored sample was never written.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_TAP0,
    ST_TAP1,
    ST_MIX
  } fdl_state_e;
endpackage

// File: rtl/fdl_addr_gen.sv
module fdl_addr_gen #(
  parameter int ADDR_W    = 11,
  parameter int OFF_W     = 8,
  parameter int INT_W     = 8,
  parameter int OFF_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] wp_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [INT_W-1:0]  int_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] off_scaled;
  logic [ADDR_W-1:0] int_ext;

  always_comb begin
    off_scaled = ADDR_W'(off_i) << OFF_SHIFT;
    int_ext    = ADDR_W'(int_i);
    base_o     = wp_i - off_scaled - int_ext - ADDR_W'(1);
  end
endmodule

// File: rtl/fdl_sample_ram.sv
module fdl_sample_ram #(
  parameter int ADDR_W = 11,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/fdl_interp.sv
module fdl_interp #(
  parameter int DW     = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DW-1:0]     tap0,
  input  logic [DW-1:0]     tap1,
  input  logic [FRAC_W-1:0] frac,
  output logic [DW-1:0]     out_q
);
  localparam int PW = DW + FRAC_W + 1;
  localparam int SW = PW + 1;

  logic signed [PW-1:0] prod0;
  logic signed [PW-1:0] prod1;
  logic signed [SW-1:0] mix_sum;
  logic [FRAC_W-1:0]    frac_inv;

  always_comb begin
    frac_inv = ~frac;
    prod0    = $signed(tap0) * $signed({1'b0, frac});
    prod1    = $signed(tap1) * $signed({1'b0, frac_inv});
    mix_sum  = SW'(prod0) + SW'(prod1);
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else if (en) out_q <= mix_sum[DW+FRAC_W-1:FRAC_W];
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(out_q));
endmodule

// File: rtl/fdl_flanger_core.sv
module fdl_flanger_core #(
  parameter int DW        = 16,
  parameter int ADDR_W    = 11,
  parameter int OFF_W     = 8,
  parameter int MOD_W     = 16,
  parameter int FRAC_W    = 8,
  parameter int OFF_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_stb,
  input  logic [DW-1:0]    smp_in,
  input  logic [OFF_W-1:0] offset_in,
  input  logic [MOD_W-1:0] mod_in,
  output logic [DW-1:0]    out_left,
  output logic [DW-1:0]    out_right,
  output logic             out_done
);
  import fdl_pkg::*;

  localparam int INT_W = MOD_W - FRAC_W;

  fdl_state_e        state;
  logic [ADDR_W-1:0] wp;
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] base_q;
  logic [DW-1:0]     wr_data_q;
  logic [FRAC_W-1:0] frac_q;
  logic [DW-1:0]     tap0_q;
  logic [DW-1:0]     rd_data;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_en;
  logic              wr_en;
  logic              mix_en;
  logic [DW-1:0]     mix_out;
  logic              done_q;

  fdl_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .INT_W(INT_W), .OFF_SHIFT(OFF_SHIFT)
  ) u_addr (
    .wp_i  (wp),
    .off_i (offset_in),
    .int_i (mod_in[MOD_W-1:FRAC_W]),
    .base_o(base_w)
  );

  always_comb begin
    wr_en   = (state == ST_WRITE);
    rd_en   = (state == ST_TAP0) || (state == ST_TAP1);
    rd_addr = (state == ST_TAP1) ? base_q + ADDR_W'(1) : base_q;
    mix_en  = (state == ST_MIX);
  end

  fdl_sample_ram #(.ADDR_W(ADDR_W), .DW(DW)) u_ram (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wp),
    .wr_data(wr_data_q),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  fdl_interp #(.DW(DW), .FRAC_W(FRAC_W)) u_mix (
    .clk  (clk),
    .rst  (rst),
    .en   (mix_en),
    .tap0 (tap0_q),
    .tap1 (rd_data),
    .frac (frac_q),
    .out_q(mix_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wp        <= '0;
      base_q    <= '0;
      wr_data_q <= '0;
      frac_q    <= '0;
      tap0_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (smp_stb) begin
          wr_data_q <= smp_in;
          base_q    <= base_w;
          frac_q    <= mod_in[FRAC_W-1:0];
          state     <= ST_WRITE;
        end
        ST_WRITE: begin
          wp    <= wp + ADDR_W'(1);
          state <= ST_TAP0;
        end
        ST_TAP0: state <= ST_TAP1;
        ST_TAP1: begin
          tap0_q <= rd_data;
          state  <= ST_MIX;
        end
        ST_MIX: begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_left  = mix_out;
  assign out_right = mix_out;
  assign out_done  = done_q;

  // R2
  wp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE) |=> (wp == $past(wp) + ADDR_W'(1)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && (state inside {ST_TAP0, ST_TAP1, ST_MIX})) |=> $stable(wp));

  // R3
  tap_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAP1) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);

  // R5
  write_first_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAP0) |-> ($past(state) == ST_WRITE));
endmodule

// File: tb/fdl_flanger_core_test.sv
`timescale 1ns/1ps
module fdl_flanger_core_test;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC  = 10;
  // {sample, offset, mod}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h1234, 8'd9,   16'h0000},
    {16'h8001, 8'd0,   16'h0080},
    {16'h7FFF, 8'd255, 16'hFF00},
    {16'hFFFF, 8'd255, 16'hFFFF},
    {16'h4000, 8'd3,   16'h0540},
    {16'hC000, 8'd1,   16'h01C3},
    {16'h0001, 8'd100, 16'h2A7F},
    {16'h5A5A, 8'd0,   16'h0001},
    {16'hA5A5, 8'd9,   16'h06FE},
    {16'h0F0F, 8'd200, 16'h9911}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_stb = 1'b0;
  logic [15:0] smp_in = '0;
  logic [7:0]  offset_in = '0;
  logic [15:0] mod_in = '0;
  logic [15:0] out_left, out_right;
  logic        out_done;

  int checks = 0;
  int failures = 0;
  logic signed [15:0] mmem [DEPTH];
  int mwp = 0;

  always #2 clk = ~clk;

  fdl_flanger_core #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_in(smp_in),
    .offset_in(offset_in), .mod_in(mod_in),
    .out_left(out_left), .out_right(out_right), .out_done(out_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_step(input logic signed [15:0] s,
                                    input int off, input logic [15:0] md);
    int base;
    longint t0, t1, f, p;
    mmem[mwp] = s;
    base = (mwp - off * 4 - int'(md[15:8]) - 1) & (DEPTH - 1);
    t0 = longint'(mmem[base]);
    t1 = longint'(mmem[(base + 1) & (DEPTH - 1)]);
    f  = longint'(md[7:0]);
    p  = t0 * f + t1 * (255 - f);
    mwp = (mwp + 1) & (DEPTH - 1);
    return int'(p >>> 8);
  endfunction

  // starts and ends on a falling edge
  task automatic run_strobe(input logic [15:0] s, input logic [7:0] off,
                            input logic [15:0] md, input int gap,
                            input bit poke, input string req);
    int exp;
    exp = model_step(s, int'(off), md);
    smp_stb = 1'b1; smp_in = s; offset_in = off; mod_in = md;
    @(negedge clk); smp_stb = 1'b0;
    @(negedge clk);
    if (poke) begin smp_stb = 1'b1; smp_in = ~s; end
    @(negedge clk); smp_stb = 1'b0;
    @(negedge clk);
    chk(out_done == 1'b0, "R7 done early", int'(out_done), 0);
    @(negedge clk);
    chk(out_done == 1'b1, "R7 done timing", int'(out_done), 1);
    chk($signed(out_left) == exp, req, int'($signed(out_left)), exp);
    chk(out_right == out_left, "R6 right", int'($signed(out_right)), int'($signed(out_left)));
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (g == 0) chk(out_done == 1'b0, "R7 pulse width", int'(out_done), 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(out_left == 16'h0, "R1 left", int'(out_left), 0);
    chk(out_right == 16'h0, "R1 right", int'(out_right), 0);
    chk(out_done == 1'b0, "R1 done", int'(out_done), 0);

    // R5, R9, R2: zero delay, back-to-back strobes through the pointer wrap
    for (int i = 0; i < DEPTH + 40; i++)
      run_strobe(16'((i * 977 + 13) ^ (i << 7)), 8'd0, 16'h0000, 0, 1'b0,
                 (i < DEPTH) ? "R5 zero delay" : "R2 after wrap");
    @(negedge clk);

    // R3, R4: table of offsets, integer parts and fractions
    for (int v = 0; v < NVEC; v++)
      run_strobe(VEC[v][39:24], VEC[v][23:16], VEC[v][15:0], 1, 1'b0, "R4 vector");

    // R8: strobe while busy is ignored, then full tap0 weight reads previous slot
    run_strobe(16'h2468, 8'd0, 16'h0000, 1, 1'b1, "R8 poked");
    run_strobe(16'h1357, 8'd0, 16'h00FF, 1, 1'b0, "R8 history");

    // R3: largest delay after more history
    run_strobe(16'h7654, 8'd255, 16'hFF80, 2, 1'b0, "R3 max delay");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule